// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block collects interrupt sources grouped into numbered levels and decides when a processor should take an interrupt. Each level owns a pending word with one bit per source. A one-bit-per-level status summary is kept next to the words and always reflects whether that level has any source pending. Agents post or clear single sources by (level, index), or wipe everything with one clear-all command.

Every cycle the block evaluates the registered state. It combines a software request vector with the pending external levels on a single priority scale: software levels are shifted down so the lowest software level maps to priority 1, and external levels keep their own number. Any pending external level outranks every software request. An interrupt is raised when that priority beats the processor's current priority level and the program counter is word aligned. When it fires, the winning priority and a summary mask of all contributing levels are held. A later commit strobe copies them into the visible summary and identifier outputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A post of (level, index) with both in range sets bit `index` of that level's pending word and marks the level as pending in the status summary at the next clock edge.
- R2: A clear of (level, index) with both in range drops that source bit. The level's status bit falls only when no other source of that level is still pending.
- R3: A clear-all command empties every pending word and the whole status summary at the next clock edge, whatever level and index it carries.
- R4: An interrupt can be taken only while some status bit is set and bits [1:0] of `pc_i` are both zero.
- R5: Software request bit i with SW_MIN <= i < SW_MAX gives candidate priority i - SW_MIN + 1 and sets bit i of the summary mask. Among software requests the highest bit wins.
- R6: A pending status bit i with EXT_MIN <= i < EXT_MAX gives candidate priority i and sets bit i of the summary mask. The highest such level wins and overrides any software candidate. The summary mask carries software and external bits together.
- R7: `take_o` is high in the cycle after an edge at which the candidate priority was nonzero and strictly above `cur_ipl_i` and R4 held. Otherwise it is low.
- R8: When an interrupt is taken, its priority and summary are held and marked valid. A `commit_i` while valid loads them into `intid_o` and `isr_o` at the next edge and clears the valid mark. A `commit_i` while not valid leaves both outputs unchanged.
- R9: A post or clear whose level is >= NUM_LEVELS or whose index is >= SRC_W changes no pending state. It sets `err_o`, which stays set until reset.
- R10: After reset, all pending words, the status summary, the held info, `take_o`, `isr_o`, `intid_o` and `err_o` are zero.
- R11: When several commands arrive in the same cycle, clear-all wins over post, and post wins over clear. A losing command has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_i | input | 1 | Post the source at (level_i, index_i) |
| clr_i | input | 1 | Clear the source at (level_i, index_i) |
| clr_all_i | input | 1 | Clear every source of every level |
| level_i | input | LVL_W = $clog2(NUM_LEVELS)+1 | Level number of the command |
| index_i | input | IDX_W = $clog2(SRC_W)+1 | Source index inside the level |
| sw_req_i | input | NUM_LEVELS | Software request vector, bit per level |
| cur_ipl_i | input | PRI_W = $clog2(NUM_LEVELS)+1 | Current processor priority level |
| pc_i | input | PC_W | Program counter; only alignment matters |
| commit_i | input | 1 | Load the held summary and identifier |
| take_o | output | 1 | Interrupt taken (registered) |
| isr_o | output | NUM_LEVELS | Committed summary mask |
| intid_o | output | PRI_W | Committed interrupt priority |
| err_o | output | 1 | Sticky flag for out-of-range commands |

## Verification
Several properties are checked on every cycle. A taken interrupt must have had a nonzero status, an aligned PC and a priority above the current level one edge earlier. Clear-all must leave the summary empty. An out-of-range post or clear must raise the error flag, and that flag never falls. A commit without held info must leave the committed outputs still. The bench covers what only sequences can show. It drives a full sweep of the software request vector and a walk through every level and index, posting and then clearing. From this it checks the software offset mapping, the precedence of external levels over software ones, and a status bit that survives until the last source of its level is gone. It also exercises commands that collide in one cycle and the ordering of commit against a fresh interrupt.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_POST    = 2'd1,
    OP_CLR     = 2'd2,
    OP_CLR_ALL = 2'd3
  } pend_op_e;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_prio_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS) + 1,
  localparam int IDX_W     = $clog2(SRC_W) + 1
) (
  input  logic             post_i,
  input  logic             clr_i,
  input  logic             clr_all_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [IDX_W-1:0] index_i,
  output pend_op_e         op_o,
  output logic             bad_o
);
  logic in_range;

  assign in_range = (int'(level_i) < NUM_LEVELS) && (int'(index_i) < SRC_W);

  always_comb begin
    op_o  = OP_NONE;
    bad_o = 1'b0;
    if (clr_all_i) begin
      op_o = OP_CLR_ALL;
    end else if (post_i) begin
      if (in_range) op_o = OP_POST;
      else          bad_o = 1'b1;
    end else if (clr_i) begin
      if (in_range) op_o = OP_CLR;
      else          bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_prio_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS) + 1,
  localparam int IDX_W     = $clog2(SRC_W) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  pend_op_e              op_i,
  input  logic                  bad_i,
  input  logic [LVL_W-1:0]      level_i,
  input  logic [IDX_W-1:0]      index_i,
  output logic [NUM_LEVELS-1:0] status_o,
  output logic                  err_o
);
  logic [SRC_W-1:0] src_bit;
  logic [SRC_W-1:0] pend_q [NUM_LEVELS];

  always_comb begin
    for (int k = 0; k < SRC_W; k++) src_bit[k] = (index_i == IDX_W'(k));
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic             hit;
    logic [SRC_W-1:0] cleared;

    assign hit     = (level_i == LVL_W'(l));
    assign cleared = pend_q[l] & ~src_bit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[l]   <= '0;
        status_o[l] <= 1'b0;
      end else if (op_i == OP_CLR_ALL) begin
        pend_q[l]   <= '0;
        status_o[l] <= 1'b0;
      end else if (hit && op_i == OP_POST) begin
        pend_q[l]   <= pend_q[l] | src_bit;
        status_o[l] <= 1'b1;
      end else if (hit && op_i == OP_CLR) begin
        pend_q[l]   <= cleared;
        status_o[l] <= |cleared;   // level stays live while any source remains
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (bad_i) err_o <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval #(
  parameter int NUM_LEVELS = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  localparam int PRI_W     = $clog2(NUM_LEVELS) + 1
) (
  input  logic [NUM_LEVELS-1:0] status_i,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  output logic [PRI_W-1:0]      ipl_o,
  output logic [NUM_LEVELS-1:0] sum_o
);
  // software first, then external, ascending: last hit wins
  always_comb begin
    ipl_o = '0;
    sum_o = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (i >= SW_MIN && i < SW_MAX && sw_req_i[i]) begin
        ipl_o    = PRI_W'(i - SW_MIN + 1);
        sum_o[i] = 1'b1;
      end
    end
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (i >= EXT_MIN && i < EXT_MAX && status_i[i]) begin
        ipl_o    = PRI_W'(i);
        sum_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_info_latch.sv
module irq_info_latch #(
  parameter int NUM_LEVELS = 32,
  localparam int PRI_W     = $clog2(NUM_LEVELS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  take_i,
  input  logic [PRI_W-1:0]      ipl_i,
  input  logic [NUM_LEVELS-1:0] sum_i,
  input  logic                  commit_i,
  output logic                  valid_o,
  output logic [NUM_LEVELS-1:0] isr_o,
  output logic [PRI_W-1:0]      intid_o
);
  logic [PRI_W-1:0]      new_ipl_q;
  logic [NUM_LEVELS-1:0] new_sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      new_ipl_q <= '0;
      new_sum_q <= '0;
      isr_o     <= '0;
      intid_o   <= '0;
    end else begin
      if (commit_i && valid_o) begin
        isr_o   <= new_sum_q;
        intid_o <= new_ipl_q;
        valid_o <= 1'b0;
      end
      // a fresh interrupt overrides the valid drop of a same-cycle commit
      if (take_i) begin
        new_ipl_q <= ipl_i;
        new_sum_q <= sum_i;
        valid_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  parameter int PC_W       = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS) + 1,
  localparam int IDX_W     = $clog2(SRC_W) + 1,
  localparam int PRI_W     = $clog2(NUM_LEVELS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  post_i,
  input  logic                  clr_i,
  input  logic                  clr_all_i,
  input  logic [LVL_W-1:0]      level_i,
  input  logic [IDX_W-1:0]      index_i,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  input  logic [PRI_W-1:0]      cur_ipl_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic                  commit_i,
  output logic                  take_o,
  output logic [NUM_LEVELS-1:0] isr_o,
  output logic [PRI_W-1:0]      intid_o,
  output logic                  err_o
);
  pend_op_e              op_w;
  logic                  bad_w;
  logic [NUM_LEVELS-1:0] status_w;
  logic [PRI_W-1:0]      ipl_w;
  logic [NUM_LEVELS-1:0] sum_w;
  logic                  info_valid_w;
  logic                  pc_aligned;
  logic                  take_now;

  irq_cmd_decode #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) u_dec (
    .post_i   (post_i),
    .clr_i    (clr_i),
    .clr_all_i(clr_all_i),
    .level_i  (level_i),
    .index_i  (index_i),
    .op_o     (op_w),
    .bad_o    (bad_w)
  );

  irq_pend_store #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op_w),
    .bad_i   (bad_w),
    .level_i (level_i),
    .index_i (index_i),
    .status_o(status_w),
    .err_o   (err_o)
  );

  irq_prio_eval #(
    .NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_eval (
    .status_i(status_w),
    .sw_req_i(sw_req_i),
    .ipl_o   (ipl_w),
    .sum_o   (sum_w)
  );

  assign pc_aligned = (pc_i & PC_W'(3)) == '0;
  assign take_now   = (|status_w) && pc_aligned && (ipl_w != '0) && (ipl_w > cur_ipl_i);

  irq_info_latch #(.NUM_LEVELS(NUM_LEVELS)) u_info (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_now),
    .ipl_i   (ipl_w),
    .sum_i   (sum_w),
    .commit_i(commit_i),
    .valid_o (info_valid_w),
    .isr_o   (isr_o),
    .intid_o (intid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) take_o <= 1'b0;
    else         take_o <= take_now;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int PC_W       = 64,
  localparam int LVL_W     = $clog2(NUM_LEVELS) + 1,
  localparam int IDX_W     = $clog2(SRC_W) + 1,
  localparam int PRI_W     = $clog2(NUM_LEVELS) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  post_i,
  input logic                  clr_i,
  input logic                  clr_all_i,
  input logic [LVL_W-1:0]      level_i,
  input logic [IDX_W-1:0]      index_i,
  input logic [PRI_W-1:0]      cur_ipl_i,
  input logic [PC_W-1:0]       pc_i,
  input logic                  commit_i,
  input logic                  take_o,
  input logic [NUM_LEVELS-1:0] isr_o,
  input logic [PRI_W-1:0]      intid_o,
  input logic                  err_o,
  input logic [NUM_LEVELS-1:0] status_w,
  input logic [PRI_W-1:0]      ipl_w,
  input logic                  info_valid_w
);
  logic bad_cmd;
  assign bad_cmd = !clr_all_i && (post_i || clr_i) &&
                   ((int'(level_i) >= NUM_LEVELS) || (int'(index_i) >= SRC_W));

  assert_take_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(status_w != '0 && pc_i[1:0] == 2'b00));

  assert_take_above_ipl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(ipl_w != '0 && ipl_w > cur_ipl_i));

  assert_clr_all_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> status_w == '0);

  assert_bad_cmd_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd |=> err_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_take_holds_info_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> info_valid_w);

  assert_idle_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !info_valid_w) |=> ($stable(isr_o) && $stable(intid_o)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .PC_W(PC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .post_i      (post_i),
  .clr_i       (clr_i),
  .clr_all_i   (clr_all_i),
  .level_i     (level_i),
  .index_i     (index_i),
  .cur_ipl_i   (cur_ipl_i),
  .pc_i        (pc_i),
  .commit_i    (commit_i),
  .take_o      (take_o),
  .isr_o       (isr_o),
  .intid_o     (intid_o),
  .err_o       (err_o),
  .status_w    (status_w),
  .ipl_w       (ipl_w),
  .info_valid_w(info_valid_w)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int NL = 12, SW = 8, SWMIN = 1, SWMAX = 6, EXMIN = 6, EXMAX = 12, PCW = 16;
  localparam int LW = $clog2(NL) + 1, IW = $clog2(SW) + 1, PW = $clog2(NL) + 1;

  logic clk = 0, rst_n = 0;
  logic post, clr, clr_all, commit;
  logic [LW-1:0]  level;
  logic [IW-1:0]  index;
  logic [NL-1:0]  sw_req;
  logic [PW-1:0]  cur_ipl;
  logic [PCW-1:0] pc;
  logic           take;
  logic [NL-1:0]  isr;
  logic [PW-1:0]  intid;
  logic           err;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NUM_LEVELS(NL), .SRC_W(SW), .SW_MIN(SWMIN), .SW_MAX(SWMAX),
                  .EXT_MIN(EXMIN), .EXT_MAX(EXMAX), .PC_W(PCW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .post_i(post), .clr_i(clr), .clr_all_i(clr_all),
    .level_i(level), .index_i(index), .sw_req_i(sw_req), .cur_ipl_i(cur_ipl),
    .pc_i(pc), .commit_i(commit), .take_o(take), .isr_o(isr), .intid_o(intid),
    .err_o(err));

  // reference state
  logic [SW-1:0] m_pend [NL];
  logic          m_take, m_valid, m_err;
  logic [NL-1:0] m_nsum, m_isr;
  logic [PW-1:0] m_nipl, m_id;
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic logic [NL-1:0] m_status();
    logic [NL-1:0] s;
    for (int l = 0; l < NL; l++) s[l] = |m_pend[l];
    return s;
  endfunction

  task automatic m_eval(output int p, output logic [NL-1:0] sm);
    logic [NL-1:0] st;
    int best_sw, best_ex;
    st = m_status();
    sm = '0; best_sw = 0; best_ex = 0;
    for (int i = SWMIN; i < SWMAX; i++)
      if (sw_req[i]) begin best_sw = i - SWMIN + 1; sm[i] = 1'b1; end
    for (int i = EXMIN; i < EXMAX; i++)
      if (st[i]) begin best_ex = i; sm[i] = 1'b1; end
    p = (best_ex != 0) ? best_ex : best_sw;
  endtask

  task automatic step(string tag);
    int p; logic [NL-1:0] sm; logic tn; int lv, ix; bit ok;
    m_eval(p, sm);
    tn = (m_status() != '0) && (pc[1:0] == 2'b00) && (p != 0) && (p > int'(cur_ipl));
    m_take = tn;
    if (commit && m_valid) begin m_isr = m_nsum; m_id = m_nipl; m_valid = 0; end
    if (tn) begin m_nsum = sm; m_nipl = PW'(p); m_valid = 1; end
    lv = int'(level); ix = int'(index); ok = (lv < NL) && (ix < SW);
    if (clr_all) begin
      for (int l = 0; l < NL; l++) m_pend[l] = '0;
    end else if (post || clr) begin
      if (!ok) m_err = 1;
      else if (post) m_pend[lv][ix] = 1'b1;
      else m_pend[lv][ix] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (take !== m_take || isr !== m_isr || intid !== m_id || err !== m_err) begin
      fails++;
      $display("FAIL %s: take=%0b isr=%h id=%0d err=%0b expected take=%0b isr=%h id=%0d err=%0b",
               tag, take, isr, intid, err, m_take, m_isr, m_id, m_err);
    end
  endtask

  task automatic idle();
    post = 0; clr = 0; clr_all = 0;
  endtask

  task automatic cmd(input bit p, input bit c, input bit a, input int l, input int i, string tag);
    post = p; clr = c; clr_all = a; level = LW'(l); index = IW'(i);
    step(tag);
    idle();
  endtask

  initial begin
    for (int l = 0; l < NL; l++) m_pend[l] = '0;
    m_take = 0; m_valid = 0; m_err = 0; m_nsum = '0; m_isr = '0; m_nipl = '0; m_id = '0;
    idle(); commit = 0; level = '0; index = '0; sw_req = '0; cur_ipl = '0; pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R10 reset state");

    // R1 R6 R8: walk every source, committing each cycle
    commit = 1;
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < SW; i++) cmd(1, 0, 0, l, i, "R1 R6 R8 post walk");
    // R2: clear walk, status holds until last source of level leaves
    for (int l = NL - 1; l >= 0; l--)
      for (int i = 0; i < SW; i++) cmd(0, 1, 0, l, i, "R2 clear walk");
    step("R2 empty after clears");

    // R5: full software sweep with status from a non-priority level 0
    cmd(1, 0, 0, 0, 3, "R1 post level0");
    for (int v = 0; v < (1 << NL); v++) begin
      sw_req = NL'(v); cur_ipl = PW'(v % 7); commit = v[0];
      step("R5 software map");
    end
    // R6: external precedence over software, with thresholds
    cmd(1, 0, 0, 7, 1, "R6 post ext7");
    for (int v = 0; v < 64; v++) begin
      sw_req = NL'(v * 37); cur_ipl = PW'(v % 13); commit = v[1];
      step("R6 R7 ext over sw");
    end
    cmd(1, 0, 0, 10, 5, "R6 post ext10");
    for (int t = 0; t < 16; t++) begin cur_ipl = PW'(t); step("R7 threshold"); end

    // R4: pc alignment
    cur_ipl = '0; commit = 1;
    for (int a = 0; a < 16; a++) begin pc = PCW'(a * 5); step("R4 pc align"); end
    pc = '0;

    // R9: out-of-range commands
    for (int l = NL; l < (1 << LW); l++) cmd(1, 0, 0, l, 0, "R9 bad level post");
    for (int i = SW; i < (1 << IW); i++) cmd(0, 1, 0, 7, i, "R9 bad index clr");
    step("R9 err sticky");

    // R11: simultaneous commands
    for (int k = 0; k < 8; k++) begin
      cmd(k[0], k[1], k[2], 8 + (k % 3), k, "R11 collide");
      step("R11 after collide");
    end

    // R3: clear-all drops everything
    cmd(1, 0, 0, 9, 2, "R3 pre post");
    cmd(1, 0, 0, 4, 6, "R3 pre post");
    cmd(0, 0, 1, 15, 15, "R3 clear all");
    sw_req = '1; step("R3 no status no take");
    sw_req = '0;

    // R8: commit with nothing held, and commit colliding with fresh interrupt
    pc = PCW'(2);
    cmd(1, 0, 0, 11, 0, "R8 post");
    commit = 1; step("R8 idle commit"); step("R8 idle commit");
    pc = '0; commit = 0; step("R8 take"); step("R8 hold");
    commit = 1; step("R8 commit+take"); step("R8 commit");
    commit = 0; step("R8 quiet");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule